// File: doc/BRIEF.md
# Command Ring Consumer Fetch Engine

This block is the controller-side consumer of a command ring. The ring lives in memory as a chain of 16-byte transfer request blocks (TRBs), each read as one 128-bit word over a synchronous read port with one cycle of latency. The engine holds a dequeue pointer and a consumer cycle state (CCS). A doorbell pulse wakes it. It then reads the TRB at the dequeue pointer. If the TRB's cycle bit matches CCS, the controller owns it: an ordinary TRB goes out on the command port together with its address, and a link TRB moves the dequeue pointer to another segment. The engine keeps fetching until it reads a TRB it does not own, then it goes idle.

A link TRB can invert CCS when it is followed. Software uses this to mark each lap around the ring. A budget counter limits how many link TRBs may be followed back to back. When the budget runs out, an error flag is set and the engine stops, so a ring made only of links cannot lock it up. The dequeue pointer and CCS are driven out as ports, so the producer can judge how much free space the ring has.

Top module: `trbRingConsumer`

## Requirements
- R1: While `rstN` is low, the dequeue pointer loads `ringBase` with bits 3:0 cleared and CCS becomes 1. After reset, `cmdValid`, `memRdEn` and `linkErr` are 0.
- R2: In the cycle after a doorbell is sampled in idle, `memRdEn` is 1 and `memAddr` equals dequeue pointer bits MEM_AW+3:4.
- R3: A TRB is owned when bit 96 (bit 0 of the fourth word) equals CCS. An owned TRB whose type field, bits 111:106 (bits 15:10 of the fourth word), is not 6 is sent out for one cycle on `cmdValid`, with `cmdTrb` holding the whole TRB and `cmdAddr` holding its address. The dequeue pointer then advances by 16.
- R4: A TRB that is not owned is not dispatched and leaves the dequeue pointer and CCS unchanged. The engine then issues no further reads until the next doorbell.
- R5: Owned TRBs at consecutive addresses are dispatched in address order after a single doorbell.
- R6: An owned TRB of type 6 (a link) is not dispatched. The dequeue pointer loads the 64-bit value whose low half is bits 31:0 and whose high half is bits 63:32, with bits 3:0 forced to 0.
- R7: When a link with bit 97 (toggle, bit 1 of the fourth word) set is followed, CCS inverts. When that bit is clear, CCS is unchanged.
- R8: Links are followed one after another until a non-link TRB is reached, and the ownership test uses the CCS in effect at that point.
- R9: At most MAX_LINKS links may be followed in a row. The budget is reloaded by each doorbell and by each dispatch. An owned link met with the budget spent is not followed: `linkErr` is set, the dequeue pointer stays on that link, and the engine goes idle. The next doorbell clears `linkErr`.
- R10: A doorbell that arrives while a fetch is in progress is remembered. If the engine later stops on a TRB it does not own, it reads that TRB once more before going idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| ringBase | input | 64 | Ring start address, loaded during reset |
| doorbell | input | 1 | Producer notification pulse |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | MEM_AW | 128-bit word address |
| memRdData | input | 128 | Read data, valid the cycle after `memRdEn` |
| cmdValid | output | 1 | One-cycle pulse: a command TRB has been dispatched |
| cmdTrb | output | 128 | Dispatched TRB |
| cmdAddr | output | 64 | Byte address of the dispatched TRB |
| deqPtr | output | 64 | Current dequeue pointer |
| ccs | output | 1 | Current consumer cycle state |
| linkErr | output | 1 | Link budget exhausted; cleared by the next doorbell |

## Verification
A wrong CCS shows up at the ports as a command that is wrongly dispatched or wrongly skipped. This appears two cycles after the read of the first TRB that follows the faulty toggle. The error is also visible directly on `ccs` once the engine is idle. A faulty dequeue update shows as a wrong `cmdAddr`, or as a wrong `memAddr` on the very next read. Directed ring images cover the following cases:
- straight runs of TRBs;
- links with and without toggle;
- chains of links;
- the link budget limit;
- a doorbell that arrives during a fetch.

Each case is checked against the dispatched address/TRB pairs, the read count and the final pointer and CCS.

// File: rtl/trbPkg.sv
package trbPkg;
  localparam int TRB_W      = 128;
  localparam int PTR_W      = 64;
  localparam int CYCLE_BIT  = 96;
  localparam int TOGGLE_BIT = 97;
  localparam int TYPE_LSB   = 106;
  localparam int TYPE_W     = 6;
  localparam logic [TYPE_W-1:0] LINK_TYPE = 6'd6;
  localparam logic [PTR_W-1:0]  TRB_BYTES = 64'd16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_EVAL  = 2'd2
  } fetchState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startFetch;
    logic dispatch;
    logic followLink;
    logic raiseErr;
  } dpCtrl_t;

  // decoded status from datapath to control
  typedef struct packed {
    logic owned;
    logic isLink;
    logic budgetOut;
  } dpStat_t;
endpackage

// File: rtl/trbFetchDatapath.sv
module trbFetchDatapath
  import trbPkg::*;
#(
  parameter int MEM_AW    = 8,
  parameter int MAX_LINKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PTR_W-1:0]  ringBase,
  input  dpCtrl_t           ctrl,
  input  logic [TRB_W-1:0]  memRdData,
  output dpStat_t           stat,
  output logic [MEM_AW-1:0] memAddr,
  output logic              cmdValid,
  output logic [TRB_W-1:0]  cmdTrb,
  output logic [PTR_W-1:0]  cmdAddr,
  output logic [PTR_W-1:0]  deqPtr,
  output logic              ccs,
  output logic              linkErr
);
  localparam int BW = $clog2(MAX_LINKS + 1);
  localparam logic [BW-1:0] BUDGET_FULL = BW'(MAX_LINKS);
  localparam logic [PTR_W-1:0] ALIGN_MASK = ~64'hF;

  logic [PTR_W-1:0] deqQ;
  logic             ccsQ;
  logic [BW-1:0]    budgetQ;
  logic [TYPE_W-1:0] typeField;
  logic [PTR_W-1:0] nextSeg;
  logic             toggleBit;

  // field decode of the word returned by memory
  assign typeField = memRdData[TYPE_LSB +: TYPE_W];
  assign toggleBit = memRdData[TOGGLE_BIT];
  assign nextSeg   = memRdData[63:0] & ALIGN_MASK;

  assign stat.owned     = (memRdData[CYCLE_BIT] == ccsQ);
  assign stat.isLink    = (typeField == LINK_TYPE);
  assign stat.budgetOut = (budgetQ == '0);

  assign memAddr = deqQ[MEM_AW+3:4];
  assign deqPtr  = deqQ;
  assign ccs     = ccsQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      deqQ     <= ringBase & ALIGN_MASK;
      ccsQ     <= 1'b1;
      budgetQ  <= BUDGET_FULL;
      linkErr  <= 1'b0;
      cmdValid <= 1'b0;
      cmdTrb   <= '0;
      cmdAddr  <= '0;
    end else begin
      cmdValid <= 1'b0;
      if (ctrl.startFetch) begin
        budgetQ <= BUDGET_FULL;
        linkErr <= 1'b0;
      end
      if (ctrl.dispatch) begin
        cmdValid <= 1'b1;
        cmdTrb   <= memRdData;
        cmdAddr  <= deqQ;
        deqQ     <= deqQ + TRB_BYTES;
        budgetQ  <= BUDGET_FULL;
      end
      if (ctrl.followLink) begin
        deqQ    <= nextSeg;
        budgetQ <= budgetQ - BW'(1);
        if (toggleBit) ccsQ <= ~ccsQ;
      end
      if (ctrl.raiseErr) linkErr <= 1'b1;
    end
  end
endmodule

// File: rtl/trbFetchCtrl.sv
module trbFetchCtrl
  import trbPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    doorbell,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    memRdEn
);
  fetchState_e stateQ, stateD;
  logic        pendingQ, pendingD;

  always_comb begin
    stateD   = stateQ;
    pendingD = pendingQ;
    ctrl     = '0;
    memRdEn  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        pendingD = 1'b0;
        if (doorbell) begin
          ctrl.startFetch = 1'b1;
          stateD = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        memRdEn = 1'b1;
        if (doorbell) pendingD = 1'b1;
        stateD = ST_EVAL;
      end
      ST_EVAL: begin
        if (doorbell) pendingD = 1'b1;
        if (!stat.owned) begin
          // R10: a late doorbell forces one more look
          pendingD = 1'b0;
          if (pendingQ || doorbell) begin
            ctrl.startFetch = 1'b1;
            stateD = ST_ISSUE;
          end else begin
            stateD = ST_IDLE;
          end
        end else if (stat.isLink) begin
          if (stat.budgetOut) begin
            ctrl.raiseErr = 1'b1;
            pendingD = 1'b0;
            stateD = ST_IDLE;
          end else begin
            ctrl.followLink = 1'b1;
            stateD = ST_ISSUE;
          end
        end else begin
          ctrl.dispatch = 1'b1;
          stateD = ST_ISSUE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      pendingQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      pendingQ <= pendingD;
    end
  end
endmodule

// File: rtl/trbRingConsumer.sv
module trbRingConsumer
  import trbPkg::*;
#(
  parameter int MEM_AW    = 8,
  parameter int MAX_LINKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [63:0]       ringBase,
  input  logic              doorbell,
  output logic              memRdEn,
  output logic [MEM_AW-1:0] memAddr,
  input  logic [127:0]      memRdData,
  output logic              cmdValid,
  output logic [127:0]      cmdTrb,
  output logic [63:0]       cmdAddr,
  output logic [63:0]       deqPtr,
  output logic              ccs,
  output logic              linkErr
);
  dpCtrl_t ctrl;
  dpStat_t stat;

  trbFetchCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .doorbell (doorbell),
    .stat     (stat),
    .ctrl     (ctrl),
    .memRdEn  (memRdEn)
  );

  trbFetchDatapath #(
    .MEM_AW    (MEM_AW),
    .MAX_LINKS (MAX_LINKS)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ringBase  (ringBase),
    .ctrl      (ctrl),
    .memRdData (memRdData),
    .stat      (stat),
    .memAddr   (memAddr),
    .cmdValid  (cmdValid),
    .cmdTrb    (cmdTrb),
    .cmdAddr   (cmdAddr),
    .deqPtr    (deqPtr),
    .ccs       (ccs),
    .linkErr   (linkErr)
  );
endmodule

// File: rtl/trbRingConsumerChk.sv
module trbRingConsumerChk #(
  parameter int MEM_AW = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRdEn,
  input logic [MEM_AW-1:0] memAddr,
  input logic              cmdValid,
  input logic [127:0]      cmdTrb,
  input logic [63:0]       cmdAddr,
  input logic [63:0]       deqPtr,
  input logic              ccs,
  input logic              linkErr
);
  // R3
  dispatch_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);
  // R3
  dispatch_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdTrb[96] == ccs);
  // R6
  no_link_dispatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdTrb[111:106] != 6'd6);
  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> deqPtr == cmdAddr + 64'd16);
  // R2
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);
  // R6
  aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    deqPtr[3:0] == 4'd0);
  // R7
  ccs_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ccs) |-> $past(memRdEn, 2));
  // R9
  err_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkErr) |-> $past(memRdEn, 2));
endmodule

bind trbRingConsumer trbRingConsumerChk #(.MEM_AW(MEM_AW)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .memRdEn  (memRdEn),
  .memAddr  (memAddr),
  .cmdValid (cmdValid),
  .cmdTrb   (cmdTrb),
  .cmdAddr  (cmdAddr),
  .deqPtr   (deqPtr),
  .ccs      (ccs),
  .linkErr  (linkErr)
);

// File: tb/tb_trbRingConsumer.sv
`timescale 1ns/1ps
module tb_trbRingConsumer;
  localparam int MEM_AW = 8;
  localparam logic [63:0] BASE = 64'h100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic doorbell = 1'b0;
  logic memRdEn;
  logic [MEM_AW-1:0] memAddr;
  logic [127:0] memRdData = '0;
  logic cmdValid;
  logic [127:0] cmdTrb;
  logic [63:0] cmdAddr, deqPtr;
  logic ccs, linkErr;

  logic [127:0] mem [0:255];
  int checks = 0;
  int errors = 0;
  int dispCount = 0;
  int readCount = 0;
  logic [63:0]  dispAddr [0:31];
  logic [127:0] dispTrb  [0:31];

  always #5 clk = ~clk;

  trbRingConsumer #(.MEM_AW(MEM_AW), .MAX_LINKS(4)) dut (
    .clk(clk), .rstN(rstN), .ringBase(BASE), .doorbell(doorbell),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .cmdValid(cmdValid), .cmdTrb(cmdTrb), .cmdAddr(cmdAddr),
    .deqPtr(deqPtr), .ccs(ccs), .linkErr(linkErr)
  );

  always @(posedge clk) if (memRdEn) memRdData <= mem[memAddr];

  always @(negedge clk) begin
    if (rstN && cmdValid && dispCount < 32) begin
      dispAddr[dispCount] = cmdAddr;
      dispTrb[dispCount]  = cmdTrb;
      dispCount++;
    end
    if (rstN && memRdEn) readCount++;
  end

  function automatic logic [127:0] mkTrb(input logic [5:0] typ, input logic cyc,
                                          input logic tog, input logic [63:0] ptr,
                                          input logic [31:0] tag);
    return {16'h0, typ, 8'h00, tog, cyc, tag, ptr[63:32], ptr[31:0]};
  endfunction

  function automatic logic [127:0] cmdT(input logic cyc, input logic [31:0] tag);
    return mkTrb(6'd23, cyc, 1'b0, 64'h0, tag);
  endfunction

  function automatic logic [127:0] linkT(input logic cyc, input logic tog,
                                          input logic [63:0] ptr);
    return mkTrb(6'd6, cyc, tog, ptr, 32'h0);
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ring();
    @(negedge clk) doorbell = 1'b1;
    @(negedge clk) doorbell = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 deqPtr", deqPtr, BASE);
    check("R1 ccs", ccs, 1);
    check("R1 cmdValid", cmdValid, 0);
    check("R1 memRdEn", memRdEn, 0);
    check("R1 linkErr", linkErr, 0);
  endtask

  task automatic testStraight();
    int d0 = dispCount;
    int r0 = readCount;
    mem[16] = cmdT(1, 32'hA0);
    mem[17] = cmdT(1, 32'hA1);
    mem[18] = cmdT(0, 32'hA2);
    @(negedge clk) doorbell = 1'b1;
    @(negedge clk) doorbell = 1'b0;
    check("R2 memRdEn after doorbell", memRdEn, 1);
    check("R2 memAddr", memAddr, 16);
    settle();
    check("R5 two dispatched", dispCount - d0, 2);
    check("R3 first addr", dispAddr[d0], 64'h100);
    check("R3 first trb", dispTrb[d0], mem[16]);
    check("R5 second addr", dispAddr[d0+1], 64'h110);
    check("R4 deq stays on unowned", deqPtr, 64'h120);
    check("R4 ccs", ccs, 1);
    check("R4 three reads", readCount - r0, 3);
    r0 = readCount;
    repeat (10) @(negedge clk);
    check("R4 idle no reads", readCount - r0, 0);
  endtask

  task automatic testLinkToggle();
    int d0 = dispCount;
    mem[18] = linkT(1, 1, 64'h40F);
    mem[64] = cmdT(0, 32'hB0);
    mem[65] = cmdT(1, 32'hB1);
    ring();
    settle();
    check("R6 one dispatched", dispCount - d0, 1);
    check("R6 link target aligned", dispAddr[d0], 64'h400);
    check("R7 ccs toggled", ccs, 0);
    check("R6 deq", deqPtr, 64'h410);
  endtask

  task automatic testLinkNoToggle();
    int d0 = dispCount;
    mem[65] = linkT(0, 0, 64'h600);
    mem[96] = cmdT(0, 32'hC0);
    mem[97] = cmdT(1, 32'hC1);
    ring();
    settle();
    check("R7 dispatch after plain link", dispCount - d0, 1);
    check("R7 addr", dispAddr[d0], 64'h600);
    check("R7 ccs unchanged", ccs, 0);
  endtask

  task automatic testLinkChain();
    int d0 = dispCount;
    mem[97]  = linkT(0, 1, 64'h700);
    mem[112] = linkT(1, 1, 64'h800);
    mem[128] = cmdT(0, 32'hD0);
    mem[129] = cmdT(1, 32'hD1);
    ring();
    settle();
    check("R8 chain dispatch", dispCount - d0, 1);
    check("R8 chain addr", dispAddr[d0], 64'h800);
    check("R8 ccs after two toggles", ccs, 0);
  endtask

  task automatic testBudget();
    int d0 = dispCount;
    mem[129] = linkT(0, 0, 64'h900);
    mem[144] = linkT(0, 0, 64'hA00);
    mem[160] = linkT(0, 0, 64'hB00);
    mem[176] = linkT(0, 0, 64'hC00);
    mem[192] = linkT(0, 0, 64'hD00);
    ring();
    settle();
    check("R9 linkErr set", linkErr, 1);
    check("R9 deq on offending link", deqPtr, 64'hC00);
    check("R9 nothing dispatched", dispCount - d0, 0);
    mem[192] = cmdT(0, 32'hE0);
    mem[193] = cmdT(1, 32'hE1);
    ring();
    check("R9 linkErr cleared", linkErr, 0);
    settle();
    check("R9 recovery dispatch", dispCount - d0, 1);
    check("R9 recovery addr", dispAddr[d0], 64'hC00);
  endtask

  task automatic testPending();
    int d0 = dispCount;
    @(negedge clk) doorbell = 1'b1;
    @(negedge clk);
    @(negedge clk) doorbell = 1'b0;
    mem[193] = cmdT(0, 32'hF0);
    mem[194] = cmdT(1, 32'hF1);
    settle();
    check("R10 late doorbell dispatch", dispCount - d0, 1);
    check("R10 addr", dispAddr[d0], 64'hC10);
    check("R10 deq", deqPtr, 64'hC20);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStraight();
    testLinkToggle();
    testLinkNoToggle();
    testLinkChain();
    testBudget();
    testPending();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule